// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms a memory address from up to three terms: a base register value, an index register value multiplied by a power of two, and a signed constant displacement. Each of the three terms may be left out. The base and index are each qualified by an enable flag. The scale is chosen by a two-bit code. The displacement carries a size code that says how many of its low bytes are meaningful. All arithmetic is 32-bit and wraps.

The index operand also carries the identifier of the register it was read from. The stack-pointer register, identifier 4, may not act as an index. When it is selected as one, the unit raises an error flag and drops the index term from the sum. The base term has no such restriction.

With `REG_OUT` set to 1 (the default), both outputs are captured in a register and appear one clock after their inputs. With `REG_OUT` set to 0, the unit is purely combinational.

Top module: `ea_gen`

## Requirements
- R1: `addr` equals base term + index term + displacement term, where each term is zero when absent.
- R2: Scale code 0, 1, 2 and 3 multiplies the index value by 1, 2, 4 and 8 respectively.
- R3: Displacement size code 0 means no displacement. Code 1 sign-extends bits 7:0, code 2 sign-extends bits 15:0, and code 3 uses all 32 bits. Bits above the selected size have no effect.
- R4: When `base_en` is 0, `base_val` has no effect on `addr`. When `idx_en` is 0, neither `idx_val` nor `idx_id` has any effect.
- R5: The sum wraps modulo 2^32.
- R6: When `idx_en` is 1 and `idx_id` is 4, `idx_err` is 1 and the index term is treated as zero.
- R7: With `REG_OUT`=1, results appear at the clock edge after the inputs are applied, and an active-low reset clears `addr` and `idx_err` to 0.
- R8: `idx_err` is 0 whenever `idx_en` is 0 or `idx_id` is not 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Index term present |
| idx_id | input | 3 | Identifier of the index register |
| idx_val | input | 32 | Index register value |
| scale | input | 2 | Index scale code |
| disp_sz | input | 2 | Displacement size code |
| disp | input | 32 | Displacement bits |
| addr | output | 32 | Effective address |
| idx_err | output | 1 | Illegal index selection |

## Verification
A wrong shift selection or a wrong sign-extension point changes `addr` by a power of two, or by a large high-bit offset. This shows one clock after the stimulus. A stale or stuck error condition shows on `idx_err` at that same edge. It also shows as an address that is off by exactly the scaled index. Each test vector is compared at the cycle after it is driven, so a fault is tied to the single input pattern that exposed it.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW       = 32,
  parameter int REGID_W  = 3,
  parameter int SP_ID    = 4,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_en,
  input  logic [AW-1:0]      base_val,
  input  logic               idx_en,
  input  logic [REGID_W-1:0] idx_id,
  input  logic [AW-1:0]      idx_val,
  input  logic [1:0]         scale,
  input  logic [1:0]         disp_sz,
  input  logic [AW-1:0]      disp,
  output logic [AW-1:0]      addr,
  output logic               idx_err
);

  logic          bad_idx;
  logic [AW-1:0] base_t, idx_t, disp_t, sum;

  assign bad_idx = idx_en && (idx_id == REGID_W'(SP_ID));
  assign base_t  = base_en ? base_val : '0;

  always_comb begin
    idx_t = '0;
    if (idx_en && !bad_idx) begin
      case (scale)
        2'd0:    idx_t = idx_val;
        2'd1:    idx_t = {idx_val[AW-2:0], 1'b0};
        2'd2:    idx_t = {idx_val[AW-3:0], 2'b0};
        default: idx_t = {idx_val[AW-4:0], 3'b0};
      endcase
    end
  end

  always_comb begin
    case (disp_sz)
      2'd1:    disp_t = {{(AW-8){disp[7]}}, disp[7:0]};
      2'd2:    disp_t = {{(AW-16){disp[15]}}, disp[15:0]};
      2'd3:    disp_t = disp;
      default: disp_t = '0;
    endcase
  end

  assign sum = base_t + idx_t + disp_t;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          addr    <= '0;
          idx_err <= 1'b0;
        end else begin
          addr    <= sum;
          idx_err <= bad_idx;
        end
      end
    end else begin : g_comb
      assign addr    = sum;
      assign idx_err = bad_idx;
    end
  endgenerate

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW      = 32,
  parameter int REGID_W = 3,
  parameter int SP_ID   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               base_en,
  input logic [AW-1:0]      base_val,
  input logic               idx_en,
  input logic [REGID_W-1:0] idx_id,
  input logic [AW-1:0]      idx_val,
  input logic [1:0]         scale,
  input logic [1:0]         disp_sz,
  input logic [AW-1:0]      disp,
  input logic [AW-1:0]      addr,
  input logic               idx_err
);

  logic sp_sel;
  assign sp_sel = idx_en && (idx_id == REGID_W'(SP_ID));

  generate
    if (REG_OUT) begin : g_seq
      // R6
      idx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_sel |=> idx_err);
      // R8
      idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_sel |=> !idx_err);
      // R4
      all_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_en && !idx_en && disp_sz == 2'd0) |=> addr == '0);
      // R6
      idx_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_en && sp_sel && disp_sz == 2'd0) |=> addr == $past(base_val));
      // R2
      scale_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_en && idx_en && !sp_sel && disp_sz == 2'd0 && scale == 2'd3)
        |=> addr == ($past(idx_val) << 3));
    end else begin : g_cmb
      // R6
      idx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_sel |-> idx_err);
      // R8
      idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_sel |-> !idx_err);
      // R4
      all_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_en && !idx_en && disp_sz == 2'd0) |-> addr == '0);
      // R6
      idx_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_en && sp_sel && disp_sz == 2'd0) |-> addr == base_val);
      // R2
      scale_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_en && idx_en && !sp_sel && disp_sz == 2'd0 && scale == 2'd3)
        |-> addr == (idx_val << 3));
    end
  endgenerate

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .REGID_W(REGID_W), .SP_ID(SP_ID), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_en = 1'b0, idx_en = 1'b0;
  logic [31:0] base_val = '0, idx_val = '0, disp = '0;
  logic [2:0]  idx_id = '0;
  logic [1:0]  scale = '0, disp_sz = '0;
  logic [31:0] addr;
  logic        idx_err;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] a; logic e; string req; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ea_gen uut (.clk(clk), .rst_n(rst_n), .base_en(base_en), .base_val(base_val),
    .idx_en(idx_en), .idx_id(idx_id), .idx_val(idx_val), .scale(scale),
    .disp_sz(disp_sz), .disp(disp), .addr(addr), .idx_err(idx_err));

  task automatic drive(input logic be, input logic [31:0] bv, input logic ie,
                       input logic [2:0] iid, input logic [31:0] iv, input logic [1:0] sc,
                       input logic [1:0] ds, input logic [31:0] dv,
                       input logic [31:0] ea, input logic ee, input string req);
    exp_t x;
    @(negedge clk);
    base_en = be; base_val = bv; idx_en = ie; idx_id = iid; idx_val = iv;
    scale = sc; disp_sz = ds; disp = dv;
    x.a = ea; x.e = ee; x.req = req;
    sb.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      tests++;
      if (addr !== x.a || idx_err !== x.e) begin
        fails++;
        $display("FAIL %s: addr=%h err=%b expected addr=%h err=%b",
                 x.req, addr, idx_err, x.a, x.e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    // R7 reset state
    if (addr !== 32'h0 || idx_err !== 1'b0) begin
      fails++;
      $display("FAIL R7: addr=%h err=%b expected addr=0 err=0", addr, idx_err);
    end
    rst_n = 1'b1;
    // R1 R3 base with byte displacement
    drive(1, 32'hf000, 0, 3'd0, 32'h0, 2'd0, 2'd1, 32'h8, 32'hf008, 0, "R1");
    // R1 base plus index
    drive(1, 32'hf000, 1, 3'd1, 32'h100, 2'd0, 2'd0, 32'h0, 32'hf100, 0, "R1");
    // R2 scale four
    drive(1, 32'hf000, 1, 3'd1, 32'h100, 2'd2, 2'd0, 32'h0, 32'hf400, 0, "R2");
    // R4 no base, scale two, word displacement
    drive(0, 32'h5555, 1, 3'd2, 32'hf000, 2'd1, 2'd3, 32'h80, 32'h1e080, 0, "R4");
    // R3 byte 0x80 sign-extends to -128
    drive(0, 32'h0, 1, 3'd2, 32'hf000, 2'd1, 2'd1, 32'h80, 32'h1df80, 0, "R3");
    // R3 halfword, upper bits ignored
    drive(1, 32'h1000, 0, 3'd0, 32'h0, 2'd0, 2'd2, 32'h1234fffe, 32'h0ffe, 0, "R3");
    // R3 size code 0 ignores disp bits
    drive(1, 32'h40, 0, 3'd0, 32'h0, 2'd0, 2'd0, 32'hdeadbeef, 32'h40, 0, "R3");
    // R5 wrap
    drive(1, 32'hfffffff0, 0, 3'd0, 32'h0, 2'd0, 2'd3, 32'h20, 32'h10, 0, "R5");
    // R6 stack pointer as index
    drive(1, 32'h2000, 1, 3'd4, 32'h77, 2'd3, 2'd1, 32'h4, 32'h2004, 1, "R6");
    // R8 id 4 with index absent
    drive(1, 32'h2000, 0, 3'd4, 32'h77, 2'd3, 2'd0, 32'h0, 32'h2000, 0, "R8");
    // R2 scale eight
    drive(0, 32'h0, 1, 3'd7, 32'h3, 2'd3, 2'd0, 32'h0, 32'h18, 0, "R2");
    // R4 base value ignored when absent, nothing present
    drive(0, 32'habcd, 0, 3'd5, 32'h99, 2'd2, 2'd0, 32'h0, 32'h0, 0, "R4");
    // R2 scale one, id 5 legal
    drive(1, 32'h10, 1, 3'd5, 32'h3, 2'd0, 2'd2, 32'hfff0, 32'h3, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule